// File: doc/BRIEF.md
# Circulating Shift-Register Word Memory

This block is a small word-addressed store whose cells are reachable only through the serial end of shift registers that advance on every clock edge. There is one register per data bit, and all of them shift together. A register normally feeds its own tail back into its head, so the contents go round the loop unchanged. A free-running slot counter tracks which word is at the serial port. A comparator marks the cycle in which that word is the one the address input names.

The user works through a one-word buffer register. The buffer can be loaded from the data input. On a matching cycle it can be filled from the addressed slot, or it can be written into that slot. A read or a write issued at an arbitrary moment therefore waits up to DEPTH cycles for its slot to come round. Addresses are relative. Whichever cell sits at the port when the counter equals address A becomes the home of A, and that cell returns to the port every DEPTH cycles.

Top module: `circ_word_mem`

## Requirements
- R1: A synchronous active-high reset clears the buffer word to zero, sets the slot counter to 0 and fills every storage cell with zero. After reset, fetching any address returns 0.
- R2: When `load_buf` is high at a clock edge, `buf_word` equals `data_in` after that edge. This holds whether or not the address matches at that edge.
- R3: When no command is high, `buf_word` keeps its value.
- R4: When `store` is high at an edge where the slot counter equals `addr`, the buffer word becomes the new contents of that slot. It is returned intact by every later fetch of that address.
- R5: When `fetch` is high at an edge where the slot counter equals `addr`, `buf_word` takes the contents of that slot after the edge.
- R6: A `fetch` or `store` at an edge where the counter differs from `addr` has no effect. The buffer word and every slot are left unchanged.
- R7: The slot counter is 0 at the first edge after reset is released and advances by one, modulo DEPTH, at every edge. Address A matches exactly at the edges where the number of edges since reset, modulo DEPTH, equals A. A command held for DEPTH cycles is therefore always served.
- R8: A store changes neither the buffer word nor any slot other than the addressed one.
- R9: Holding `fetch` or `store` for several match periods gives the same result as a single served command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; every storage register shifts on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_buf | input | 1 | Load the buffer word from `data_in` |
| fetch | input | 1 | Copy the addressed slot into the buffer on its match cycle |
| store | input | 1 | Write the buffer into the addressed slot on its match cycle |
| data_in | input | WIDTH | Word to be loaded into the buffer |
| addr | input | AW | Relative slot address |
| buf_word | output | WIDTH | Current buffer register contents |

## Verification
Two paths can act in the same cycle: the buffer load path, and the match decision that steers both the serial write and the capture into the buffer. The bench applies `load_buf` exactly at an edge where the bench's own edge count says the address matches. It expects the buffer to take `data_in` and no slot to change, which a later fetch of every address confirms. The bench also pulses single-cycle fetches and stores at the matching edge and at a mismatched edge. It judges the result against a model counter derived from R7 and a model array of slot contents.

// File: rtl/circ_mem_pkg.sv
package circ_mem_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_FETCH = 2'd2,
        OP_STORE = 2'd3
    } op_e;

    // Commands are one-hot by contract; load is given precedence regardless.
    function automatic op_e pick_op(input logic ld, input logic fe, input logic st);
        if (ld)      return OP_LOAD;
        else if (fe) return OP_FETCH;
        else if (st) return OP_STORE;
        else         return OP_HOLD;
    endfunction

endpackage

// File: rtl/circ_slot_tracker.sv
module circ_slot_tracker #(
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] pos,
    output logic          hit
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)              pos <= '0;
        else if (pos == LAST) pos <= '0;
        else                  pos <= pos + AW'(1);
    end

    assign hit = (pos == addr);
endmodule

// File: rtl/circ_lane.sv
module circ_lane #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    output logic tail
);
    logic [DEPTH-1:0] cells;
    logic             head_in;

    assign tail    = cells[DEPTH-1];
    assign head_in = wr_en ? wr_bit : tail;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) cells <= '0;
                else     cells <= head_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) cells <= '0;
                else     cells <= {cells[DEPTH-2:0], head_in};
            end
        end
    endgenerate
endmodule

// File: rtl/circ_buffer.sv
module circ_buffer
    import circ_mem_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic             hit,
    input  logic [WIDTH-1:0] ext_word,
    input  logic [WIDTH-1:0] port_word,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  q <= ext_word;
                OP_FETCH: if (hit) q <= port_word;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/circ_word_mem.sv
module circ_word_mem
    import circ_mem_pkg::*;
#(
    parameter int WIDTH = 2,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_buf,
    input  logic             fetch,
    input  logic             store,
    input  logic [WIDTH-1:0] data_in,
    input  logic [AW-1:0]    addr,
    output logic [WIDTH-1:0] buf_word
);
    op_e              op;
    logic [AW-1:0]    pos_q;
    logic             slot_hit;
    logic             write_now;
    logic [WIDTH-1:0] port_w;
    logic [WIDTH-1:0] buf_q;

    assign op        = pick_op(load_buf, fetch, store);
    assign write_now = (op == OP_STORE) && slot_hit;
    assign buf_word  = buf_q;

    circ_slot_tracker #(.DEPTH(DEPTH), .AW(AW)) u_track (
        .clk  (clk),
        .rst  (rst),
        .addr (addr),
        .pos  (pos_q),
        .hit  (slot_hit)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_lane
        circ_lane #(.DEPTH(DEPTH)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (write_now),
            .wr_bit (buf_q[b]),
            .tail   (port_w[b])
        );
    end

    circ_buffer #(.WIDTH(WIDTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .hit       (slot_hit),
        .ext_word  (data_in),
        .port_word (port_w),
        .q         (buf_q)
    );
endmodule

// File: rtl/circ_word_mem_chk.sv
module circ_word_mem_chk #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             load_buf,
    input logic             fetch,
    input logic             store,
    input logic [WIDTH-1:0] data_in,
    input logic [AW-1:0]    addr,
    input logic [AW-1:0]    pos,
    input logic [WIDTH-1:0] port_w,
    input logic [WIDTH-1:0] buf_word
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (buf_word == '0) && (pos == '0));

    a_r7_counter_steps: assert property (@(posedge clk) disable iff (rst)
        (pos != LAST) |=> (pos == $past(pos) + AW'(1)));

    a_r7_counter_wraps: assert property (@(posedge clk) disable iff (rst)
        (pos == LAST) |=> (pos == '0));

    a_r2_load_takes_input: assert property (@(posedge clk) disable iff (rst)
        load_buf |=> (buf_word == $past(data_in)));

    a_r5_fetch_on_match: assert property (@(posedge clk) disable iff (rst)
        (fetch && !load_buf && !store && pos == addr) |=> (buf_word == $past(port_w)));

    a_r6_fetch_off_match: assert property (@(posedge clk) disable iff (rst)
        (fetch && !load_buf && !store && pos != addr) |=> $stable(buf_word));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!load_buf && !fetch && !store) |=> $stable(buf_word));

    a_r8_store_keeps_buffer: assert property (@(posedge clk) disable iff (rst)
        (store && !load_buf && !fetch) |=> $stable(buf_word));
endmodule

bind circ_word_mem circ_word_mem_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_buf (load_buf),
    .fetch    (fetch),
    .store    (store),
    .data_in  (data_in),
    .addr     (addr),
    .pos      (pos_q),
    .port_w   (port_w),
    .buf_word (buf_word)
);

// File: tb/circ_word_mem_test.sv
`timescale 1ns/1ps
module circ_word_mem_test;
    localparam int WIDTH = 2;
    localparam int DEPTH = 4;
    localparam int AW    = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load_buf = 1'b0;
    logic             fetch = 1'b0;
    logic             store = 1'b0;
    logic [WIDTH-1:0] data_in = '0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] buf_word;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    int model_pos = 0;
    logic [WIDTH-1:0] mem_model [DEPTH];
    bit finished = 0;

    always #2.5 clk = ~clk;

    circ_word_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .load_buf(load_buf), .fetch(fetch), .store(store),
        .data_in(data_in), .addr(addr), .buf_word(buf_word)
    );

    // R7: edges counted since reset, modulo DEPTH, gives the slot at the port
    always @(posedge clk) begin
        edges <= edges + 1;
        if (rst) model_pos <= 0;
        else     model_pos <= (model_pos + 1) % DEPTH;
    end

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        load_buf = 0; fetch = 0; store = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [WIDTH-1:0] v);
        data_in = v; load_buf = 1;
        @(negedge clk);
        load_buf = 0;
    endtask

    task automatic held_fetch(input int a, input int periods);
        addr = AW'(a); fetch = 1;
        repeat (DEPTH * periods) @(negedge clk);
        fetch = 0;
    endtask

    task automatic held_store(input int a, input int periods);
        addr = AW'(a); store = 1;
        repeat (DEPTH * periods) @(negedge clk);
        store = 0;
    endtask

    task automatic wait_pos(input int p);
        while (model_pos != p) @(negedge clk);
    endtask

    task automatic verify_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            do_load(~mem_model[a]);
            held_fetch(a, 1);
            check(req, buf_word, mem_model[a]);
        end
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) mem_model[a] = '0;
        repeat (3) @(negedge clk);
        check("R1 buffer after reset", buf_word, '0);
        rst = 0;

        // R1: every slot reads zero after reset
        verify_all("R1 slot zero after reset");

        // R2/R3/R8/R4: fill each slot with a distinct pattern
        for (int a = 0; a < DEPTH; a++) begin
            logic [WIDTH-1:0] v;
            v = WIDTH'((a * 3 + 1) % (1 << WIDTH));
            do_load(v);
            check("R2 load", buf_word, v);
            idle(3);
            check("R3 hold", buf_word, v);
            held_store(a, 1);
            check("R8 store keeps buffer", buf_word, v);
            mem_model[a] = v;
        end
        idle(DEPTH * 2);
        verify_all("R4 R8 contents after fills");

        // R5/R6/R7: single-cycle fetch exactly on and off the match edge
        for (int a = 0; a < DEPTH; a++) begin
            do_load(~mem_model[a]);
            addr = AW'(a);
            wait_pos((a + 1) % DEPTH);
            fetch = 1; @(negedge clk); fetch = 0;
            check("R6 fetch off match", buf_word, ~mem_model[a]);
            wait_pos(a);
            fetch = 1; @(negedge clk); fetch = 0;
            check("R5 R7 fetch on match", buf_word, mem_model[a]);
        end

        // R4/R6: single-cycle stores on and off the match edge, exhaustive values at one slot
        for (int v = 0; v < (1 << WIDTH); v++) begin
            logic [WIDTH-1:0] w;
            w = WIDTH'(v) ^ mem_model[2];
            do_load(w);
            addr = 2'd2;
            wait_pos(3);
            store = 1; @(negedge clk); store = 0;
            verify_all("R6 store off match");
            do_load(w);
            addr = 2'd2;
            wait_pos(2);
            store = 1; @(negedge clk); store = 0;
            if (v != 0) mem_model[2] = w;
            verify_all("R4 store on match");
        end

        // Load on the very edge where the address matches: buffer takes input, no slot moves
        addr = 2'd1;
        wait_pos(1);
        data_in = ~mem_model[1]; load_buf = 1; @(negedge clk); load_buf = 0;
        check("R2 load on match edge", buf_word, ~mem_model[1]);
        verify_all("R2 load leaves slots");

        // R9: commands held across several match periods
        do_load(2'b10);
        held_store(0, 3);
        mem_model[0] = 2'b10;
        check("R9 held store buffer", buf_word, 2'b10);
        do_load(2'b01);
        held_fetch(0, 3);
        check("R9 held fetch", buf_word, 2'b10);
        verify_all("R9 slots after held commands");

        // R1: reset mid-run clears everything again
        rst = 1; @(negedge clk); @(negedge clk); rst = 0;
        check("R1 buffer after second reset", buf_word, '0);
        for (int a = 0; a < DEPTH; a++) mem_model[a] = '0;
        verify_all("R1 slots after second reset");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (!finished && edges > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", edges, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule